// File: doc/BRIEF.md
# Locked Byte Test-and-Set Sequencer

This block performs an atomic byte test-and-set for a processor core. A one-cycle start pulse carries a byte address and a flag that marks the address as non-cacheable. For a cacheable address the sequencer first probes the data cache. On a hit with a dirty line it requests a write-back of that line and then invalidates it. On a hit with a clean line it only invalidates it. On a miss nothing is purged. After that it runs a locked byte read and a byte write on the memory bus.

The write stores the byte that was read, with its top bit forced to one. A zero-test flag reports whether the byte was zero. The bus lock stays asserted from the read request until the write has been acknowledged, so no other master can get in between the two accesses. A one-cycle done pulse signals the end of the operation, and the flag is valid while done is high.

Top module: `lockrmw_seq`

## Requirements
- R1: On a cache hit with the dirty input high (cacheable address), the block raises a write-back request, holds it until acknowledged, then pulses the invalidate output for one cycle, all before the first memory request.
- R2: On a cache hit with the dirty input low, the block pulses invalidate once and raises no write-back request.
- R3: On a cache miss there is neither write-back nor invalidate. For a non-cacheable address the block also skips the cache probe and raises no write-back or invalidate, whatever the hit and dirty inputs say.
- R4: The zero flag `t_o` becomes 1 when the byte returned by the read is 8'h00, and 0 otherwise.
- R5: Exactly one write follows the read, to the same address, with data equal to the byte read OR 8'h80 (bit 7 set).
- R6: `mem_lock_o` is high whenever `mem_req_o` is high, stays high from the read request through the write acknowledge, and is low in the cycle after the write acknowledge.
- R7: Each write-back or memory request stays high, with a stable address and direction, until its acknowledge arrives.
- R8: A start pulse that arrives while the block is busy is ignored: it causes no extra access and touches no other address.
- R9: `done_o` is a one-cycle pulse in the cycle after the write acknowledge.
- R10: While `rst_n` is low, the block returns to idle at each clock edge, with lock, done, busy and `t_o` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, sampled when idle |
| addr_i | input | AW | Byte address of the operation |
| uncached_i | input | 1 | Address is non-cacheable, skip the purge |
| probe_en_o | output | 1 | Cache lookup strobe |
| probe_addr_o | output | AW | Address looked up in the cache |
| probe_hit_i | input | 1 | Lookup hit, valid while probe_en_o is high |
| probe_dirty_i | input | 1 | Hit line is dirty, valid while probe_en_o is high |
| wb_req_o | output | 1 | Line write-back request |
| wb_ack_i | input | 1 | Line write-back acknowledge |
| inval_o | output | 1 | Clear the valid bit of the probed line |
| mem_req_o | output | 1 | Memory bus request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Memory byte address |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid with the acknowledge |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_lock_o | output | 1 | Bus lock |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | Operation-complete pulse |
| t_o | output | 1 | Zero-test result |

## Verification
On every cycle the assertions check the lock rules: lock is present with every request and drops right after the write acknowledge. They also check that requests are held until acknowledged, that the written byte carries bit 7, that purge activity never overlaps a memory access, and that the zero flag matches the byte captured at the read acknowledge. Only the bench scenarios can show which purge path each hit, dirty and cacheability combination takes. The same goes for the memory contents after the write, the ignored start pulse, and the state after a reset that lands in the middle of a locked sequence.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROBE,
        ST_WBACK,
        ST_INVAL,
        ST_READ,
        ST_WRITE
    } seq_state_e;
endpackage

// File: rtl/lrs_purge_dec.sv
// Chooses the purge path from the cache lookup result.
module lrs_purge_dec (
    input  logic hit_i,
    input  logic dirty_i,
    output logic need_wb_o,
    output logic need_inval_o
);
    always_comb begin
        need_wb_o    = hit_i && dirty_i;
        need_inval_o = hit_i;
    end
endmodule

// File: rtl/lrs_byte_op.sv
// Zero test and flag-bit set on the byte returned by the locked read.
module lrs_byte_op #(
    parameter int DW      = 8,
    parameter int SET_BIT = 7
) (
    input  logic [DW-1:0] rd_i,
    output logic          zero_o,
    output logic [DW-1:0] set_o
);
    localparam logic [DW-1:0] SET_MASK = {{(DW-1){1'b0}}, 1'b1} << SET_BIT;

    always_comb begin
        zero_o = (rd_i == '0);
        set_o  = rd_i | SET_MASK;
    end
endmodule

// File: rtl/lockrmw_seq.sv
module lockrmw_seq
    import lrs_pkg::*;
#(
    parameter int AW      = 32,
    parameter int DW      = 8,
    parameter int SET_BIT = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] addr_i,
    input  logic          uncached_i,
    output logic          probe_en_o,
    output logic [AW-1:0] probe_addr_o,
    input  logic          probe_hit_i,
    input  logic          probe_dirty_i,
    output logic          wb_req_o,
    input  logic          wb_ack_i,
    output logic          inval_o,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic [DW-1:0] mem_rdata_i,
    input  logic          mem_ack_i,
    output logic          mem_lock_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          t_o
);
    typedef struct packed {
        seq_state_e    state;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          t;
        logic          done;
    } seq_s;

    seq_s q, d;

    logic          need_wb, need_inval;
    logic          rd_zero;
    logic [DW-1:0] rd_set;

    lrs_purge_dec i_purge (
        .hit_i        (probe_hit_i),
        .dirty_i      (probe_dirty_i),
        .need_wb_o    (need_wb),
        .need_inval_o (need_inval)
    );

    lrs_byte_op #(.DW(DW), .SET_BIT(SET_BIT)) i_byte (
        .rd_i   (mem_rdata_i),
        .zero_o (rd_zero),
        .set_o  (rd_set)
    );

    // Next-state computation
    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    d.addr  = addr_i;
                    d.state = uncached_i ? ST_READ : ST_PROBE;
                end
            end
            ST_PROBE: begin
                if (need_wb)         d.state = ST_WBACK;
                else if (need_inval) d.state = ST_INVAL;
                else                 d.state = ST_READ;
            end
            ST_WBACK: if (wb_ack_i) d.state = ST_INVAL;
            ST_INVAL: d.state = ST_READ;
            ST_READ: begin
                if (mem_ack_i) begin
                    d.t     = rd_zero;
                    d.wdata = rd_set;
                    d.state = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (mem_ack_i) begin
                    d.done  = 1'b1;
                    d.state = ST_IDLE;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state <= ST_IDLE;
            q.addr  <= '0;
            q.wdata <= '0;
            q.t     <= 1'b0;
            q.done  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    // Outputs decoded from the registered state
    always_comb begin
        probe_en_o   = (q.state == ST_PROBE);
        probe_addr_o = q.addr;
        wb_req_o     = (q.state == ST_WBACK);
        inval_o      = (q.state == ST_INVAL);
        mem_req_o    = (q.state == ST_READ) || (q.state == ST_WRITE);
        mem_we_o     = (q.state == ST_WRITE);
        mem_addr_o   = q.addr;
        mem_wdata_o  = q.wdata;
        mem_lock_o   = mem_req_o;
        busy_o       = (q.state != ST_IDLE);
        done_o       = q.done;
        t_o          = q.t;
    end
endmodule

// File: rtl/lrs_checker.sv
module lrs_checker #(
    parameter int AW      = 32,
    parameter int DW      = 8,
    parameter int SET_BIT = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wb_req_o,
    input logic          wb_ack_i,
    input logic          inval_o,
    input logic          mem_req_o,
    input logic          mem_we_o,
    input logic [AW-1:0] mem_addr_o,
    input logic [DW-1:0] mem_wdata_o,
    input logic [DW-1:0] mem_rdata_i,
    input logic          mem_ack_i,
    input logic          mem_lock_o,
    input logic          busy_o,
    input logic          done_o,
    input logic          t_o
);
    p_wb_then_inval_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req_o && wb_ack_i) |=> inval_o);

    // Purge activity never overlaps a memory access (R1, R2)
    p_purge_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req_o || inval_o) |-> !mem_req_o);

    p_inval_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        inval_o |=> !inval_o);

    p_zero_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_we_o && mem_ack_i) |=> (t_o == ($past(mem_rdata_i) == '0)));

    p_wdata_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o) |-> mem_wdata_o[SET_BIT]);

    p_lock_with_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> mem_lock_o);

    p_lock_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o && mem_ack_i) |=> !mem_lock_o);

    p_read_to_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_we_o && mem_ack_i) |=> (mem_req_o && mem_we_o && mem_lock_o));

    p_mem_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_we_o) && $stable(mem_addr_o)));

    p_wb_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req_o && !wb_ack_i) |=> wb_req_o);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o && mem_ack_i) |=> done_o);

    p_reset_idle_r10: assert property (@(posedge clk)
        !rst_n |=> (!mem_lock_o && !done_o && !busy_o && !t_o));
endmodule

bind lockrmw_seq lrs_checker #(.AW(AW), .DW(DW), .SET_BIT(SET_BIT)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wb_req_o    (wb_req_o),
    .wb_ack_i    (wb_ack_i),
    .inval_o     (inval_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i),
    .mem_ack_i   (mem_ack_i),
    .mem_lock_o  (mem_lock_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .t_o         (t_o)
);

// File: tb/test_lockrmw_seq.sv
`timescale 1ns/1ps
module test_lockrmw_seq;
    localparam int AW = 32;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic          uncached_i = 1'b0;
    logic          probe_en_o;
    logic [AW-1:0] probe_addr_o;
    logic          probe_hit_i = 1'b0;
    logic          probe_dirty_i = 1'b0;
    logic          wb_req_o;
    logic          wb_ack_i = 1'b0;
    logic          inval_o;
    logic          mem_req_o, mem_we_o, mem_lock_o, busy_o, done_o, t_o;
    logic [AW-1:0] mem_addr_o;
    logic [DW-1:0] mem_wdata_o;
    logic [DW-1:0] mem_rdata_i = '0;
    logic          mem_ack_i = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    lockrmw_seq #(.AW(AW), .DW(DW)) i_lockrmw_seq (.*);

    int checks = 0;
    int failures = 0;
    int lat = 0;
    int mcnt = 0, wcnt = 0;
    int n_probe = 0, n_wb = 0, n_inval = 0, n_rd = 0, n_wr = 0;
    int lock_err = 0, hold_err = 0, order_err = 0;
    int cyc = 0, last_purge = -1, first_mem = -1;
    bit in_rmw = 0;
    bit prev_mem_pend = 0, prev_wb_pend = 0;
    logic [7:0] mem [16];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitors and responders, all at the falling edge
    always @(negedge clk) begin
        cyc++;
        if (probe_en_o) n_probe++;
        if (inval_o) begin n_inval++; last_purge = cyc; end
        if (wb_req_o) last_purge = cyc;
        if (mem_req_o && first_mem < 0) first_mem = cyc;
        if (mem_req_o && last_purge >= 0 && last_purge >= first_mem) order_err++;
        if ((mem_req_o || in_rmw) && !mem_lock_o) lock_err++;
        if (prev_mem_pend && !mem_req_o) hold_err++;
        if (prev_wb_pend && !wb_req_o) hold_err++;
        prev_mem_pend = 0;
        prev_wb_pend = 0;
        if (!rst_n) begin
            mem_ack_i = 0; wb_ack_i = 0; mcnt = 0; wcnt = 0; in_rmw = 0;
        end else begin
            if (mem_ack_i) begin
                mem_ack_i = 0; mcnt = 0;
            end else if (mem_req_o) begin
                if (mcnt >= lat) begin
                    mem_ack_i = 1;
                    if (mem_we_o) begin
                        mem[mem_addr_o[3:0]] = mem_wdata_o; n_wr++; in_rmw = 0;
                    end else begin
                        mem_rdata_i = mem[mem_addr_o[3:0]]; n_rd++; in_rmw = 1;
                    end
                end else begin
                    mcnt++; prev_mem_pend = 1;
                end
            end
            if (wb_ack_i) begin
                wb_ack_i = 0; wcnt = 0;
            end else if (wb_req_o) begin
                if (wcnt >= lat) begin wb_ack_i = 1; n_wb++; end
                else begin wcnt++; prev_wb_pend = 1; end
            end
        end
    end

    typedef struct packed {
        logic [3:0] addr;
        logic       unc;
        logic       hit;
        logic       dirty;
        logic [7:0] init;
        logic [2:0] lat;
        logic       exp_t;
        logic [1:0] exp_wb;
        logic [1:0] exp_inval;
        logic [1:0] exp_probe;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{4'h1, 1'b0, 1'b1, 1'b1, 8'h00, 3'd0, 1'b1, 2'd1, 2'd1, 2'd1},  // R1 dirty hit
        '{4'h2, 1'b0, 1'b1, 1'b0, 8'h5A, 3'd1, 1'b0, 2'd0, 2'd1, 2'd1},  // R2 clean hit
        '{4'h3, 1'b0, 1'b0, 1'b0, 8'h00, 3'd2, 1'b1, 2'd0, 2'd0, 2'd1},  // R3 miss
        '{4'h4, 1'b1, 1'b1, 1'b1, 8'h80, 3'd0, 1'b0, 2'd0, 2'd0, 2'd0},  // R3 uncached
        '{4'h5, 1'b0, 1'b1, 1'b1, 8'hFF, 3'd3, 1'b0, 2'd1, 2'd1, 2'd1},
        '{4'h6, 1'b1, 1'b0, 1'b0, 8'h00, 3'd1, 1'b1, 2'd0, 2'd0, 2'd0},
        '{4'h7, 1'b0, 1'b1, 1'b0, 8'h01, 3'd0, 1'b0, 2'd0, 2'd1, 2'd1},
        '{4'h8, 1'b0, 1'b0, 1'b1, 8'h7F, 3'd2, 1'b0, 2'd0, 2'd0, 2'd1}   // dirty without hit
    };

    task automatic clear_counts();
        n_probe = 0; n_wb = 0; n_inval = 0; n_rd = 0; n_wr = 0;
        lock_err = 0; hold_err = 0; order_err = 0; last_purge = -1; first_mem = -1;
    endtask

    task automatic pulse_start(input logic [3:0] a, input logic unc);
        @(negedge clk);
        start_i = 1; addr_i = {28'h0, a}; uncached_i = unc;
        @(negedge clk);
        start_i = 0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 0;
        for (int i = 0; i < 300; i++) begin
            if (done_o) begin seen = 1; break; end
            @(negedge clk);
        end
    endtask

    bit seen;
    logic [7:0] exp_b;

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 8'h11;
        repeat (3) @(negedge clk);
        // R10: reset state
        check(!mem_lock_o && !done_o && !busy_o && !t_o, "R10 reset", {mem_lock_o, done_o, busy_o, t_o}, 0);
        rst_n = 1;

        foreach (VEC[k]) begin
            mem[VEC[k].addr] = VEC[k].init;
            lat = VEC[k].lat;
            probe_hit_i = VEC[k].hit;
            probe_dirty_i = VEC[k].dirty;
            clear_counts();
            pulse_start(VEC[k].addr, VEC[k].unc);
            wait_done(seen);
            check(seen, "R9 done seen", seen, 1);
            check(t_o == VEC[k].exp_t, "R4 zero flag", t_o, VEC[k].exp_t);
            exp_b = VEC[k].init | 8'h80;
            check(mem[VEC[k].addr] == exp_b, "R5 written byte", mem[VEC[k].addr], exp_b);
            check(n_rd == 1 && n_wr == 1, "R5 one read one write", n_rd * 16 + n_wr, 17);
            check(n_wb == VEC[k].exp_wb, "R1 write-back count", n_wb, VEC[k].exp_wb);
            check(n_inval == VEC[k].exp_inval, "R2 invalidate count", n_inval, VEC[k].exp_inval);
            check(n_probe == VEC[k].exp_probe, "R3 probe count", n_probe, VEC[k].exp_probe);
            check(order_err == 0, "R1 purge before memory", order_err, 0);
            check(lock_err == 0, "R6 lock held", lock_err, 0);
            check(hold_err == 0, "R7 request held", hold_err, 0);
            @(negedge clk);
            check(!done_o && !mem_lock_o, "R9 R6 pulse end", {done_o, mem_lock_o}, 0);
        end

        // R8: start while busy is ignored
        mem[4'h9] = 8'h22; mem[4'hA] = 8'h33;
        lat = 4; probe_hit_i = 1; probe_dirty_i = 1;
        clear_counts();
        pulse_start(4'h9, 1'b0);
        pulse_start(4'hA, 1'b1);
        wait_done(seen);
        repeat (8) @(negedge clk);
        check(mem[4'hA] == 8'h33, "R8 other address untouched", mem[4'hA], 8'h33);
        check(n_rd == 1 && n_wr == 1, "R8 no extra access", n_rd * 16 + n_wr, 17);
        check(mem[4'h9] == 8'hA2 && !busy_o, "R8 first op done", mem[4'h9], 8'hA2);

        // R10: reset in the middle of a locked sequence, after T was set
        mem[4'hB] = 8'h00; lat = 0;
        pulse_start(4'hB, 1'b1);
        wait_done(seen);
        check(t_o == 1'b1, "R4 zero byte", t_o, 1);
        mem[4'hC] = 8'h44; lat = 6;
        pulse_start(4'hC, 1'b1);
        for (int i = 0; i < 20 && !mem_lock_o; i++) @(negedge clk);
        check(mem_lock_o, "R6 lock during read", mem_lock_o, 1);
        rst_n = 0;
        @(negedge clk);
        check(!mem_lock_o && !busy_o && !t_o && !done_o, "R10 mid-op reset",
              {mem_lock_o, busy_o, t_o, done_o}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        check(mem[4'hC] == 8'h44 && !mem_req_o, "R10 no write after reset", mem[4'hC], 8'h44);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule